// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits behind a receive MAC. It looks at the 48-bit destination address at the head of each frame and decides whether the frame should be kept. A frame begins with a one-cycle start strobe on `rx_sof`. After that strobe, the destination octets arrive one at a time on `rx_byte`, each qualified by `rx_byte_vld`. Idle cycles are allowed between octets. The first octet on the wire is the most significant octet of the address.

While the octets arrive, the block runs a byte-serial Ethernet CRC-32 over them. It also keeps the address for an exact compare against the station address. When the sixth octet is taken, the block produces a one-cycle decision strobe together with the accept result and a multicast flag.

Three mode inputs set the policy, in priority order: promiscuous, pass-all-multicast, and hash filtering for multicast. A unicast frame that is not promiscuous must match the station address exactly. Broadcast frames are always kept.

Top module: `rxaf_filter`

## Requirements
- R1: After reset, `dec_vld`, `dec_accept` and `dec_mcast` are 0. Octets that arrive before the first `rx_sof` are ignored and produce no decision.
- R2: `dec_vld` pulses for exactly one cycle, in the cycle after the sixth qualified octet of a frame. Cycles with `rx_byte_vld` low are not counted. Octets after the sixth are ignored until the next `rx_sof`.
- R3: `rx_sof` restarts both the octet count and the CRC. A partial address received before it has no effect on the next decision. An octet presented in the same cycle as `rx_sof` is not taken.
- R4: `dec_mcast` equals bit 0 of the first received octet. It is presented in the same cycle as `dec_vld`.
- R5: When `promisc_en` is 1, every frame is accepted, whatever the address, the hash table or the other mode bits.
- R6: The broadcast address (all 48 bits set) is accepted in every mode.
- R7: When `pass_all_mc_en` is 1, every multicast frame is accepted without looking at the hash table.
- R8: The hash index is bits 31:26 of the complemented CRC. The CRC starts at 0xFFFFFFFF, uses the reflected polynomial 0xEDB88320, and takes each octet least significant bit first. With `hash_en` set and pass-all-multicast clear, a non-broadcast multicast frame is accepted exactly when its table bit is 1. Index bit 5 selects `hash_hi` (1) or `hash_lo` (0), and index bits 4:0 select the bit within that word.
- R9: With `hash_en` set, a table of all ones accepts every multicast frame.
- R10: A unicast frame, when not promiscuous, is accepted exactly when its address equals {`sta_addr_hi`, `sta_addr_lo`}. The first octet is compared with `sta_addr_hi[15:8]`, and the last octet with `sta_addr_lo[7:0]`.
- R11: With all three mode bits clear, a multicast frame other than broadcast is rejected.
- R12: `dec_accept` and `dec_mcast` are 0 in every cycle in which `dec_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sof | input | 1 | Start-of-frame strobe, one cycle before the first octet |
| rx_byte_vld | input | 1 | Qualifies `rx_byte` |
| rx_byte | input | 8 | Destination address octet, first octet first |
| sta_addr_hi | input | 16 | Upper 16 bits of the station address (first two octets) |
| sta_addr_lo | input | 32 | Lower 32 bits of the station address (last four octets) |
| hash_hi | input | 32 | Multicast hash table, entries 32 to 63 |
| hash_lo | input | 32 | Multicast hash table, entries 0 to 31 |
| promisc_en | input | 1 | Accept all frames |
| pass_all_mc_en | input | 1 | Accept all multicast frames |
| hash_en | input | 1 | Filter multicast through the hash table |
| dec_vld | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted (valid with `dec_vld`) |
| dec_mcast | output | 1 | Destination is multicast (valid with `dec_vld`) |

## Verification
The internal state is small: an armed flag, an octet count, the shifted address and the running CRC. None of it is visible until the decision cycle of the frame that holds it.

A count or arm error shows at the ports within the same frame, as a strobe that comes early, late, twice, or not at all. A corrupted CRC or address register shows only as a wrong accept result. That appears for the CRC only on a multicast frame in hash mode, and for the address only on a unicast compare. For this reason the bench checks every strobe cycle against a model, across random modes, tables and address classes, and inserts random idle gaps between octets.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int unsigned OCTET_W     = 8;
    localparam int unsigned DA_OCTETS   = 6;
    localparam int unsigned CRC_W       = 32;
    localparam int unsigned HASH_IDX_W  = 6;
    localparam int unsigned HASH_WORD_W = 32;

    localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // filtering policy bits, grouped for the decision logic
    typedef struct packed {
        logic promisc;
        logic pass_mc;
        logic hash;
    } rxaf_mode_t;

    // registered decision presented at the block edge
    typedef struct packed {
        logic vld;
        logic accept;
        logic mcast;
    } rxaf_dec_t;

endpackage

// File: rtl/rxaf_octet_track.sv
// Counts qualified octets after a start strobe and shifts them into an
// address register; flags the beat that completes the destination field.
module rxaf_octet_track #(
    parameter int unsigned OCT_W = rxaf_pkg::OCTET_W,
    parameter int unsigned N_OCT = rxaf_pkg::DA_OCTETS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sof,
    input  logic                   beat,
    input  logic [OCT_W-1:0]       octet,
    output logic                   take,
    output logic                   last,
    output logic [OCT_W*N_OCT-1:0] da_nx
);

    localparam int unsigned DA_W  = OCT_W * N_OCT;
    localparam int unsigned CNT_W = $clog2(N_OCT + 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [DA_W-1:0]  da;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        take  = 1'b0;
        last  = 1'b0;
        if (sof) begin
            trk_d.armed = 1'b1;
            trk_d.cnt   = '0;
            trk_d.da    = '0;
        end else if (beat && trk_q.armed) begin
            take      = 1'b1;
            trk_d.da  = {trk_q.da[DA_W-OCT_W-1:0], octet};
            trk_d.cnt = trk_q.cnt + 1'b1;
            if (trk_q.cnt == CNT_W'(N_OCT - 1)) begin
                last        = 1'b1;
                trk_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign da_nx = trk_d.da;

endmodule

// File: rtl/rxaf_crc_engine.sv
// Byte-serial reflected CRC; exposes the hash index of the value that
// includes the octet currently presented.
module rxaf_crc_engine #(
    parameter int unsigned       OCT_W = rxaf_pkg::OCTET_W,
    parameter int unsigned       CRC_W = rxaf_pkg::CRC_W,
    parameter int unsigned       IDX_W = rxaf_pkg::HASH_IDX_W,
    parameter logic [CRC_W-1:0]  SEED  = rxaf_pkg::CRC_SEED,
    parameter logic [CRC_W-1:0]  POLY  = rxaf_pkg::CRC_POLY_REFL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [OCT_W-1:0] octet,
    output logic [IDX_W-1:0] hash_idx
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_st_t;

    crc_st_t          st_d, st_q;
    logic [CRC_W-1:0] crc_step;
    logic [CRC_W-1:0] crc_inv;

    always_comb begin
        crc_step = st_q.crc;
        for (int i = 0; i < int'(OCT_W); i++) begin
            if (crc_step[0] ^ octet[i]) begin
                crc_step = (crc_step >> 1) ^ POLY;
            end else begin
                crc_step = crc_step >> 1;
            end
        end
        st_d = st_q;
        if (clr) begin
            st_d.crc = SEED;
        end else if (take) begin
            st_d.crc = crc_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crc <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_inv  = ~crc_step;
    assign hash_idx = crc_inv[CRC_W-1 -: IDX_W];

endmodule

// File: rtl/rxaf_match.sv
// Pure decision logic: classifies the address and applies mode priority.
module rxaf_match #(
    parameter int unsigned OCT_W  = rxaf_pkg::OCTET_W,
    parameter int unsigned N_OCT  = rxaf_pkg::DA_OCTETS,
    parameter int unsigned IDX_W  = rxaf_pkg::HASH_IDX_W,
    parameter int unsigned WORD_W = rxaf_pkg::HASH_WORD_W
) (
    input  logic [OCT_W*N_OCT-1:0]        da,
    input  logic [IDX_W-1:0]              hash_idx,
    input  logic [OCT_W*N_OCT-WORD_W-1:0] sta_hi,
    input  logic [WORD_W-1:0]             sta_lo,
    input  logic [WORD_W-1:0]             tbl_hi,
    input  logic [WORD_W-1:0]             tbl_lo,
    input  rxaf_pkg::rxaf_mode_t          mode,
    output logic                          accept,
    output logic                          mcast
);

    localparam int unsigned DA_W  = OCT_W * N_OCT;
    localparam int unsigned TBL_W = 2 * WORD_W;

    logic [DA_W-1:0]  sta;
    logic [TBL_W-1:0] tbl;
    logic [N_OCT-1:0] oct_eq;
    logic [N_OCT-1:0] oct_ones;
    logic             sta_hit;
    logic             bcast;
    logic             tbl_hit;

    assign sta = {sta_hi, sta_lo};
    assign tbl = {tbl_hi, tbl_lo};

    genvar g;
    generate
        for (g = 0; g < int'(N_OCT); g++) begin : g_oct
            assign oct_eq[g]   = (da[g*OCT_W +: OCT_W] == sta[g*OCT_W +: OCT_W]);
            assign oct_ones[g] = &da[g*OCT_W +: OCT_W];
        end
    endgenerate

    assign sta_hit = &oct_eq;
    assign bcast   = &oct_ones;
    assign mcast   = da[DA_W-OCT_W];
    assign tbl_hit = tbl[hash_idx];

    always_comb begin
        if (mode.promisc) begin
            accept = 1'b1;
        end else if (bcast) begin
            accept = 1'b1;
        end else if (mcast) begin
            if (mode.pass_mc) begin
                accept = 1'b1;
            end else if (mode.hash) begin
                accept = tbl_hit;
            end else begin
                accept = 1'b0;
            end
        end else begin
            accept = sta_hit;
        end
    end

endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter #(
    parameter int unsigned OCT_W  = rxaf_pkg::OCTET_W,
    parameter int unsigned N_OCT  = rxaf_pkg::DA_OCTETS,
    parameter int unsigned IDX_W  = rxaf_pkg::HASH_IDX_W,
    parameter int unsigned WORD_W = rxaf_pkg::HASH_WORD_W,
    parameter int unsigned STA_HI_W = OCT_W * N_OCT - WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_sof,
    input  logic                rx_byte_vld,
    input  logic [OCT_W-1:0]    rx_byte,
    input  logic [STA_HI_W-1:0] sta_addr_hi,
    input  logic [WORD_W-1:0]   sta_addr_lo,
    input  logic [WORD_W-1:0]   hash_hi,
    input  logic [WORD_W-1:0]   hash_lo,
    input  logic                promisc_en,
    input  logic                pass_all_mc_en,
    input  logic                hash_en,
    output logic                dec_vld,
    output logic                dec_accept,
    output logic                dec_mcast
);

    localparam int unsigned DA_W = OCT_W * N_OCT;

    logic                 take;
    logic                 last;
    logic [DA_W-1:0]      da_nx;
    logic [IDX_W-1:0]     hash_idx;
    logic                 acc_c;
    logic                 mc_c;
    rxaf_pkg::rxaf_mode_t mode;
    rxaf_pkg::rxaf_dec_t  out_d, out_q;

    assign mode = '{promisc: promisc_en, pass_mc: pass_all_mc_en, hash: hash_en};

    rxaf_octet_track #(
        .OCT_W (OCT_W),
        .N_OCT (N_OCT)
    ) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .sof   (rx_sof),
        .beat  (rx_byte_vld),
        .octet (rx_byte),
        .take  (take),
        .last  (last),
        .da_nx (da_nx)
    );

    rxaf_crc_engine #(
        .OCT_W (OCT_W),
        .IDX_W (IDX_W)
    ) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_sof),
        .take     (take),
        .octet    (rx_byte),
        .hash_idx (hash_idx)
    );

    rxaf_match #(
        .OCT_W  (OCT_W),
        .N_OCT  (N_OCT),
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) u_match (
        .da       (da_nx),
        .hash_idx (hash_idx),
        .sta_hi   (sta_addr_hi),
        .sta_lo   (sta_addr_lo),
        .tbl_hi   (hash_hi),
        .tbl_lo   (hash_lo),
        .mode     (mode),
        .accept   (acc_c),
        .mcast    (mc_c)
    );

    always_comb begin
        out_d = '0;
        if (last) begin
            out_d.vld    = 1'b1;
            out_d.accept = acc_c;
            out_d.mcast  = mc_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dec_vld    = out_q.vld;
    assign dec_accept = out_q.accept;
    assign dec_mcast  = out_q.mcast;

endmodule

// File: rtl/rxaf_filter_chk.sv
module rxaf_filter_chk #(
    parameter int unsigned WORD_W = rxaf_pkg::HASH_WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_sof,
    input logic              rx_byte_vld,
    input logic [WORD_W-1:0] hash_hi,
    input logic [WORD_W-1:0] hash_lo,
    input logic              promisc_en,
    input logic              pass_all_mc_en,
    input logic              hash_en,
    input logic              dec_vld,
    input logic              dec_accept,
    input logic              dec_mcast
);

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld); // R2

    AST_VLD_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |-> $past(rx_byte_vld && !rx_sof)); // R2

    AST_SOF_NO_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sof |=> !dec_vld); // R3

    AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && $past(promisc_en)) |-> dec_accept); // R5

    AST_PASS_MC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_mcast && $past(pass_all_mc_en)) |-> dec_accept); // R7

    AST_FULL_TABLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_mcast && $past(hash_en) && $past(&{hash_hi, hash_lo})) |-> dec_accept); // R9

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> (!dec_accept && !dec_mcast)); // R12

endmodule

bind rxaf_filter rxaf_filter_chk #(.WORD_W(WORD_W)) u_rxaf_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_sof         (rx_sof),
    .rx_byte_vld    (rx_byte_vld),
    .hash_hi        (hash_hi),
    .hash_lo        (hash_lo),
    .promisc_en     (promisc_en),
    .pass_all_mc_en (pass_all_mc_en),
    .hash_en        (hash_en),
    .dec_vld        (dec_vld),
    .dec_accept     (dec_accept),
    .dec_mcast      (dec_mcast)
);

// File: tb/rxaf_filter_bench.sv
module rxaf_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_byte_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [15:0] sta_addr_hi = 16'h0200;
    logic [31:0] sta_addr_lo = 32'h1234_5678;
    logic [31:0] hash_hi = '0;
    logic [31:0] hash_lo = '0;
    logic        promisc_en = 1'b0;
    logic        pass_all_mc_en = 1'b0;
    logic        hash_en = 1'b0;
    logic        dec_vld;
    logic        dec_accept;
    logic        dec_mcast;

    int n_checks = 0;
    int n_fails  = 0;

    always #2ns clk = ~clk;

    rxaf_filter u_rxaf_filter (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_sof         (rx_sof),
        .rx_byte_vld    (rx_byte_vld),
        .rx_byte        (rx_byte),
        .sta_addr_hi    (sta_addr_hi),
        .sta_addr_lo    (sta_addr_lo),
        .hash_hi        (hash_hi),
        .hash_lo        (hash_lo),
        .promisc_en     (promisc_en),
        .pass_all_mc_en (pass_all_mc_en),
        .hash_en        (hash_en),
        .dec_vld        (dec_vld),
        .dec_accept     (dec_accept),
        .dec_mcast      (dec_mcast)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // hash index from the CRC rule of R8
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] n;
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ a[40 - 8*k + b]) c = (c >> 1) ^ 32'hEDB8_8320;
                else                        c = c >> 1;
            end
        end
        n = ~c;
        return n[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] a);
        logic [63:0] t = {hash_hi, hash_lo};
        if (promisc_en)  return 1'b1;             // R5
        if (&a)          return 1'b1;             // R6
        if (a[40]) begin
            if (pass_all_mc_en) return 1'b1;      // R7
            if (hash_en)        return t[ref_idx(a)]; // R8
            return 1'b0;                          // R11
        end
        return a == {sta_addr_hi, sta_addr_lo};   // R10
    endfunction

    task automatic send_frame(input logic [47:0] a, input int gmax, input string req);
        logic exp_acc;
        exp_acc = ref_accept(a);
        rx_sof = 1'b1;
        @(negedge clk);
        rx_sof = 1'b0;
        for (int i = 0; i < 6; i++) begin
            int g;
            g = (gmax > 0) ? int'($urandom_range(gmax, 0)) : 0;
            for (int j = 0; j < g; j++) begin
                rx_byte_vld = 1'b0;
                rx_byte     = 8'($urandom);
                @(negedge clk);
                chk(64'(dec_vld), 64'd0, "R2", "strobe during gap");
            end
            rx_byte_vld = 1'b1;
            rx_byte     = a[47 - 8*i -: 8];
            @(negedge clk);
            if (i < 5) chk(64'(dec_vld), 64'd0, "R2", "early strobe");
        end
        rx_byte_vld = 1'b0;
        chk(64'(dec_vld), 64'd1, "R2", "strobe after sixth octet");
        chk(64'(dec_accept), 64'(exp_acc), req, "accept");
        chk(64'(dec_mcast), 64'(a[40]), "R4", "multicast flag");
        @(negedge clk);
        chk(64'(dec_vld), 64'd0, "R2", "strobe longer than one cycle");
        chk(64'({dec_accept, dec_mcast}), 64'd0, "R12", "outputs while idle");
    endtask

    task automatic loose_octets(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            rx_byte_vld = 1'b1;
            rx_byte     = 8'($urandom);
            @(negedge clk);
            chk(64'(dec_vld), 64'd0, req, "stray octet made a decision");
        end
        rx_byte_vld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic [47:0] mc_a;
        logic [5:0]  ix;
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        chk(64'({dec_vld, dec_accept, dec_mcast}), 64'd0, "R1", "outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(64'({dec_vld, dec_accept, dec_mcast}), 64'd0, "R1", "outputs after reset");
        loose_octets(8, "R1");

        // unicast to station, no modes
        send_frame({sta_addr_hi, sta_addr_lo}, 0, "R10");
        send_frame({sta_addr_hi, sta_addr_lo} ^ 48'h1, 0, "R10");
        // broadcast with no modes
        send_frame(48'hFFFF_FFFF_FFFF, 0, "R6");
        // multicast, no modes
        send_frame(48'h0100_5E00_0001, 0, "R11");
        chk(64'(ref_accept(48'h0100_5E00_0001)), 64'd0, "R11", "model multicast rejection");

        // extra octets after the sixth are ignored
        send_frame({sta_addr_hi, sta_addr_lo}, 1, "R10");
        loose_octets(4, "R2");

        // restart mid address
        rx_sof = 1'b1; @(negedge clk); rx_sof = 1'b0;
        loose_octets(3, "R3");
        send_frame({sta_addr_hi, sta_addr_lo}, 0, "R3");

        // single table bit
        mc_a = 48'h0100_5E12_3456;
        ix   = ref_idx(mc_a);
        hash_en = 1'b1;
        {hash_hi, hash_lo} = 64'd1 << ix;
        send_frame(mc_a, 0, "R8");
        chk(64'(dec_vld), 64'd0, "R8", "idle after hash frame");
        {hash_hi, hash_lo} = ~(64'd1 << ix);
        send_frame(mc_a, 2, "R8");
        // full table
        {hash_hi, hash_lo} = '1;
        send_frame(48'h3300_0000_00FB, 0, "R9");
        send_frame(48'h0180_C200_0000, 1, "R9");
        // pass-all ignores empty table
        {hash_hi, hash_lo} = '0;
        pass_all_mc_en = 1'b1;
        send_frame(mc_a, 0, "R7");
        // promiscuous beats everything
        pass_all_mc_en = 1'b0;
        promisc_en = 1'b1;
        send_frame(48'h0A0B_0C0D_0E0F, 0, "R5");
        send_frame(mc_a, 0, "R5");
        promisc_en = 1'b0;

        // constrained random
        for (int f = 0; f < 400; f++) begin
            logic [47:0] a;
            int          cls;
            if (f % 8 == 0) begin
                {promisc_en, pass_all_mc_en, hash_en} = 3'($urandom);
                if ($urandom_range(3, 0) == 0) promisc_en = 1'b0;
                hash_hi = $urandom;
                hash_lo = $urandom;
                sta_addr_hi = 16'($urandom) & 16'hFEFF;
                sta_addr_lo = $urandom;
            end
            cls = int'($urandom_range(9, 0));
            a   = {16'($urandom), 32'($urandom)};
            if (cls < 3)      a = {sta_addr_hi, sta_addr_lo};
            else if (cls < 4) a = '1;
            else if (cls < 7) a[40] = 1'b1;
            else              a[40] = 1'b0;
            send_frame(a, 2, a[40] ? (hash_en ? "R8" : "R7") : "R10");
        end

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule